// File: doc/BRIEF.md
# Video Memory Write Drain Engine

This block sits on the write path between a DMA or CPU word source and three video memories: the pattern memory (VRAM), the colour table and the scroll table. Sixteen-bit source words are taken into a small FIFO at the full source rate. A slot-driven drain then writes each word to the selected memory. The source is held off only when the FIFO has no free entry, or around a refresh slot.

The cost of draining one word depends on the target and on a width setting. With a narrow (byte-wide) VRAM, one word needs two write slots, one byte in each. A wide (word-wide) VRAM takes the whole word in one slot, and the colour and scroll tables always do. A slot lasts the same time in every case, so only the bytes moved per slot change. As a result, the rate at which the source can run depends on the mode. A refresh slot costs the drain one write and holds the source off for two cycles.

The transfer setup is taken from plain inputs on a load strobe: the target, the VRAM width, the start address and the address step. After each word's last write slot, the destination address advances by the step.

Top module: `vid_wr_engine`

## Requirements
- R1: After reset, `fifo_empty`=1, `fifo_full`=0, `mem_we`=0 and `src_ready`=1.
- R2: When neither the current cycle nor the previous one is a refresh slot, `src_ready` is high whenever the FIFO is not full. A word is accepted on each clock edge where `src_valid` and `src_ready` are both high.
- R3: Once DEPTH (4) words are held, `fifo_full`=1 and `src_ready`=0. Further words are not accepted, and no word is lost or duplicated.
- R4: Narrow VRAM mode applies when target code 2'b00 (VRAM) is set with `cfg_wide`=0. Each word then drains in two slots, with `mem_byte`=1 and the byte in `mem_data[7:0]` (bits 15:8 zero). The high byte is written first, to the even address {addr[16:1],0}. The low byte follows, to the odd address {addr[16:1],1}.
- R5: Wide VRAM mode (target 2'b00, `cfg_wide`=1) drains each word in one slot, with `mem_byte`=0, the full word on `mem_data` and the address on `mem_addr`.
- R6: Targets 2'b01 (colour table) and 2'b10 (scroll table) always drain one full word per slot, with `mem_byte`=0, whatever `cfg_wide` is. `mem_tgt` carries the target code of each write.
- R7: The destination address starts at `cfg_addr` on `cfg_load` and advances by `cfg_step` after the last slot of every word.
- R8: In a cycle with `refresh`=1, no drain write is made, so `mem_we` is 0 after the next edge. `src_ready` is 0 during the refresh cycle and during the cycle after it.
- R9: A word leaves the FIFO only after its last slot. In narrow VRAM mode, the first byte slot leaves the occupancy, and therefore `fifo_full`, unchanged.
- R10: With a slot in every cycle and a continuous source, wide mode accepts a word every cycle without stalling. Narrow mode settles to one word per two cycles.
- R11: With the FIFO empty, a write slot produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load transfer setup (only while idle) |
| cfg_tgt | input | 2 | Target: 00 VRAM, 01 colour table, 10 scroll table |
| cfg_wide | input | 1 | 1 = word-wide VRAM, 0 = byte-wide VRAM |
| cfg_addr | input | 17 | Start byte address |
| cfg_step | input | 8 | Address step per word |
| src_valid | input | 1 | Source word present |
| src_data | input | 16 | Source word |
| src_ready | output | 1 | Word accepted at the next edge if valid |
| slot_en | input | 1 | A memory write slot is offered this cycle |
| refresh | input | 1 | This cycle is a refresh slot |
| mem_we | output | 1 | Write strobe (registered) |
| mem_tgt | output | 2 | Target code of this write |
| mem_addr | output | 17 | Write byte address |
| mem_data | output | 16 | Write data (byte in [7:0] when mem_byte) |
| mem_byte | output | 1 | 1 = single-byte write |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_empty | output | 1 | FIFO holds no word |

## Verification
The assertions assume that `cfg_load` is pulsed only while the FIFO is empty and no byte pair is half written. They also assume that `cfg_tgt` never carries 2'b11. The bench reloads the setup only after it has waited for the drain to go idle and for every expected write to be seen, and it uses only the three defined target codes. Refresh pulses are given one cycle at a time, with at least two quiet cycles between them, so the two-cycle source hold of one pulse never overlaps the next.

// File: rtl/vwd_pkg.sv
package vwd_pkg;
    typedef enum logic [1:0] {
        TGT_VRAM   = 2'b00,
        TGT_COLOR  = 2'b01,
        TGT_SCROLL = 2'b10
    } tgt_e;
endpackage

// File: rtl/vwd_fifo.sv
module vwd_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
    p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/vwd_drain.sv
module vwd_drain
    import vwd_pkg::*;
#(
    parameter int AW     = 17,
    parameter int DW     = 16,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  tgt_e              cfg_tgt,
    input  logic              cfg_wide,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [STEP_W-1:0] cfg_step,
    input  logic              slot_en,
    input  logic              refresh,
    input  logic              fifo_empty,
    input  logic [DW-1:0]     fifo_head,
    output logic              fifo_pop,
    output logic              mem_we,
    output logic [1:0]        mem_tgt,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_data,
    output logic              mem_byte
);
    localparam int HW = DW / 2;

    typedef struct packed {
        tgt_e              tgt;
        logic              wide;
        logic [AW-1:0]     addr;
        logic [STEP_W-1:0] step;
        logic              phase;
        logic              we;
        tgt_e              otgt;
        logic [AW-1:0]     oaddr;
        logic [DW-1:0]     odata;
        logic              obyte;
    } st_t;

    st_t  st_d, st_q;
    logic byte_mode, slot_ok, last_slot;

    always_comb begin
        st_d      = st_q;
        byte_mode = (st_q.tgt == TGT_VRAM) && !st_q.wide;
        slot_ok   = slot_en && !refresh && !fifo_empty;
        last_slot = !byte_mode || st_q.phase;
        fifo_pop  = slot_ok && last_slot;

        st_d.we = slot_ok;
        if (slot_ok) begin
            st_d.otgt  = st_q.tgt;
            st_d.obyte = byte_mode;
            if (byte_mode) begin
                st_d.oaddr = {st_q.addr[AW-1:1], st_q.phase};
                st_d.odata = {{HW{1'b0}},
                              st_q.phase ? fifo_head[HW-1:0] : fifo_head[DW-1:HW]};
            end else begin
                st_d.oaddr = st_q.addr;
                st_d.odata = fifo_head;
            end
            if (last_slot) begin
                st_d.phase = 1'b0;
                st_d.addr  = st_q.addr + AW'(st_q.step);
            end else begin
                st_d.phase = 1'b1;
            end
        end

        if (cfg_load) begin
            st_d.tgt   = cfg_tgt;
            st_d.wide  = cfg_wide;
            st_d.addr  = cfg_addr;
            st_d.step  = cfg_step;
            st_d.phase = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we   = st_q.we;
    assign mem_tgt  = st_q.otgt;
    assign mem_addr = st_q.oaddr;
    assign mem_data = st_q.odata;
    assign mem_byte = st_q.obyte;

    p_refresh_drops_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> !mem_we);
    p_even_byte_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_byte && !mem_addr[0]) |-> st_q.phase);
    p_word_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_byte) |-> !st_q.phase);
    p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |=> !mem_we);
    p_byte_only_vram_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_byte) |-> (mem_tgt == TGT_VRAM));
endmodule

// File: rtl/vwd_src_gate.sv
module vwd_src_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh,
    input  logic fifo_full,
    input  logic src_valid,
    output logic src_ready,
    output logic push
);
    typedef struct packed {
        logic rf_hold;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.rf_hold = refresh;
        src_ready    = !fifo_full && !refresh && !st_q.rf_hold;
        push         = src_valid && src_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_refresh_second_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> !src_ready);
endmodule

// File: rtl/vid_wr_engine.sv
module vid_wr_engine
    import vwd_pkg::*;
#(
    parameter int AW     = 17,
    parameter int DW     = 16,
    parameter int STEP_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_tgt,
    input  logic              cfg_wide,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [STEP_W-1:0] cfg_step,
    input  logic              src_valid,
    input  logic [DW-1:0]     src_data,
    output logic              src_ready,
    input  logic              slot_en,
    input  logic              refresh,
    output logic              mem_we,
    output logic [1:0]        mem_tgt,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_data,
    output logic              mem_byte,
    output logic              fifo_full,
    output logic              fifo_empty
);
    logic          push, pop;
    logic [DW-1:0] head;

    vwd_src_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .refresh   (refresh),
        .fifo_full (fifo_full),
        .src_valid (src_valid),
        .src_ready (src_ready),
        .push      (push)
    );

    vwd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (src_data),
        .pop   (pop),
        .head  (head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    vwd_drain #(.AW(AW), .DW(DW), .STEP_W(STEP_W)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_tgt    (tgt_e'(cfg_tgt)),
        .cfg_wide   (cfg_wide),
        .cfg_addr   (cfg_addr),
        .cfg_step   (cfg_step),
        .slot_en    (slot_en),
        .refresh    (refresh),
        .fifo_empty (fifo_empty),
        .fifo_head  (head),
        .fifo_pop   (pop),
        .mem_we     (mem_we),
        .mem_tgt    (mem_tgt),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .mem_byte   (mem_byte)
    );

    p_full_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !src_ready);
    p_load_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> fifo_empty);
    p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));
endmodule

// File: tb/tb_vid_wr_engine.sv
module tb_vid_wr_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [1:0]  cfg_tgt = 2'b00;
    logic        cfg_wide = 1'b0;
    logic [16:0] cfg_addr = '0;
    logic [7:0]  cfg_step = '0;
    logic        src_valid = 1'b0;
    logic [15:0] src_data = '0;
    logic        src_ready;
    logic        slot_en = 1'b0;
    logic        refresh = 1'b0;
    logic        mem_we, mem_byte, fifo_full, fifo_empty;
    logic [1:0]  mem_tgt;
    logic [16:0] mem_addr;
    logic [15:0] mem_data;

    always #5 clk = ~clk;

    vid_wr_engine dut (.*);

    typedef struct {
        logic [16:0] addr;
        logic [15:0] data;
        logic        byt;
        logic [1:0]  tgt;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [1:0]  m_tgt;
    logic        m_wide;
    logic [16:0] m_addr;
    logic [7:0]  m_step;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // monitor: compare every write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected write", int'(mem_addr), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(mem_addr == e.addr, e.tag, "addr", int'(mem_addr), int'(e.addr));
                check(mem_data == e.data, e.tag, "data", int'(mem_data), int'(e.data));
                check(mem_byte == e.byt,  e.tag, "byte", int'(mem_byte), int'(e.byt));
                check(mem_tgt == e.tgt,   e.tag, "tgt",  int'(mem_tgt),  int'(e.tgt));
            end
        end
    end

    task automatic expect_word(input logic [15:0] w);
        exp_t e;
        if (m_tgt == 2'b00 && !m_wide) begin
            e.addr = {m_addr[16:1], 1'b0}; e.data = {8'h00, w[15:8]};
            e.byt = 1'b1; e.tgt = m_tgt; e.tag = "R4";
            exp_q.push_back(e);
            e.addr = {m_addr[16:1], 1'b1}; e.data = {8'h00, w[7:0]};
            exp_q.push_back(e);
        end else begin
            e.addr = m_addr; e.data = w; e.byt = 1'b0; e.tgt = m_tgt;
            e.tag = (m_tgt == 2'b00) ? "R5" : "R6";
            exp_q.push_back(e);
        end
        m_addr = m_addr + 17'(m_step);
    endtask

    task automatic setup(input logic [1:0] t, input logic w,
                         input logic [16:0] a, input logic [7:0] s);
        @(negedge clk);
        cfg_tgt = t; cfg_wide = w; cfg_addr = a; cfg_step = s; cfg_load = 1'b1;
        m_tgt = t; m_wide = w; m_addr = a; m_step = s;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic send(input int n, input logic [15:0] base, output int cyc);
        int i = 0;
        cyc = 0;
        while (i < n) begin
            logic [15:0] w;
            w = base + 16'(i * 16'h0111);
            @(negedge clk);
            cyc++;
            src_valid = 1'b1;
            src_data  = w;
            if (src_ready) begin
                expect_word(w);
                i++;
            end
        end
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    task automatic drain_all(input string tag);
        slot_en = 1'b1;
        for (int k = 0; k < 40 && !(fifo_empty && exp_q.size() == 0); k++) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, tag, "writes outstanding", exp_q.size(), 0);
        check(fifo_empty == 1'b1, tag, "fifo_empty after drain", int'(fifo_empty), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(fifo_empty == 1'b1, "R1", "fifo_empty", int'(fifo_empty), 1);
        check(fifo_full == 1'b0,  "R1", "fifo_full",  int'(fifo_full), 0);
        check(mem_we == 1'b0,     "R1", "mem_we",     int'(mem_we), 0);
        check(src_ready == 1'b1,  "R1", "src_ready",  int'(src_ready), 1);
        rst_n = 1'b1;

        // R11: slots offered with nothing queued produce no writes (monitor flags any)
        slot_en = 1'b1;
        repeat (5) @(negedge clk);
        check(mem_we == 1'b0, "R11", "write while empty", int'(mem_we), 0);

        // R4, R7: narrow VRAM, odd start address, step 2
        setup(2'b00, 1'b0, 17'h01001, 8'd2);
        send(6, 16'hA1B2, cyc);
        drain_all("R4");

        // R5, R7: wide VRAM with address wrap
        setup(2'b00, 1'b1, 17'h1FFFC, 8'd2);
        send(5, 16'h1234, cyc);
        drain_all("R5");

        // R6: colour table with width bit 0, scroll table with step 4
        setup(2'b01, 1'b0, 17'h00040, 8'd2);
        send(4, 16'h0EEE, cyc);
        drain_all("R6");
        setup(2'b10, 1'b0, 17'h00100, 8'd4);
        send(4, 16'h5A5A, cyc);
        drain_all("R6");

        // R3, R9: fill with no slots, narrow mode
        setup(2'b00, 1'b0, 17'h02000, 8'd2);
        slot_en = 1'b0;
        send(4, 16'hC0DE, cyc);
        check(cyc == 4, "R2", "cycles to accept 4 words", cyc, 4);
        check(fifo_full == 1'b1, "R3", "fifo_full", int'(fifo_full), 1);
        check(src_ready == 1'b0, "R3", "src_ready when full", int'(src_ready), 0);
        src_valid = 1'b1; src_data = 16'hDEAD;
        repeat (3) @(negedge clk);
        check(src_ready == 1'b0, "R3", "still stalled", int'(src_ready), 0);
        check(mem_we == 1'b0, "R3", "no write without slot", int'(mem_we), 0);
        src_valid = 1'b0;
        slot_en = 1'b1;
        @(negedge clk);
        slot_en = 1'b0;
        check(mem_we == 1'b1, "R9", "first byte written", int'(mem_we), 1);
        check(fifo_full == 1'b1, "R9", "full after first byte slot", int'(fifo_full), 1);
        @(negedge clk);
        check(fifo_full == 1'b1, "R9", "full held", int'(fifo_full), 1);
        drain_all("R3");

        // R8: refresh slot
        setup(2'b00, 1'b1, 17'h03000, 8'd2);
        slot_en = 1'b0;
        send(2, 16'h7700, cyc);
        @(negedge clk);
        refresh = 1'b1; slot_en = 1'b1;
        #1;
        check(src_ready == 1'b0, "R8", "src_ready in refresh cycle", int'(src_ready), 0);
        @(negedge clk);
        refresh = 1'b0;
        check(mem_we == 1'b0, "R8", "write lost to refresh", int'(mem_we), 0);
        check(src_ready == 1'b0, "R8", "src_ready after refresh", int'(src_ready), 0);
        @(negedge clk);
        check(mem_we == 1'b1, "R8", "write resumes", int'(mem_we), 1);
        check(src_ready == 1'b1, "R2", "src_ready restored", int'(src_ready), 1);
        drain_all("R8");

        // R10: throughput, continuous slots
        setup(2'b00, 1'b1, 17'h04000, 8'd2);
        slot_en = 1'b1;
        send(20, 16'h0101, cyc);
        check(cyc == 20, "R10", "wide cycles for 20 words", cyc, 20);
        drain_all("R10");
        setup(2'b00, 1'b0, 17'h05000, 8'd2);
        slot_en = 1'b1;
        send(20, 16'h0202, cyc);
        check(cyc >= 30 && cyc <= 40, "R10", "narrow cycles for 20 words", cyc, 36);
        drain_all("R10");

        // R7: scroll with large step checks address arithmetic
        setup(2'b10, 1'b1, 17'h1FF80, 8'd200);
        send(3, 16'h3C3C, cyc);
        drain_all("R7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule